// File: doc/BRIEF.md
# Serial Transceiver with Hardware Flow Control

This block is an asynchronous serial transmitter and receiver. Software drives it through a two-register port. One register holds the configuration and shows live status. The other register sends a character when written and takes the oldest received character when read.

Each frame carries one start bit, eight data bits sent least significant bit first, an optional parity bit (even or odd) and one stop bit. A programmable divider sets the length of one bit in clock cycles. The receiver stores characters in a two-slot buffer, and each stored character carries its own parity-error and framing-error flags.

Flow control works in both directions, and each direction is enabled on its own. A clear-to-send input decides only whether a new frame may start; a frame already on the line always finishes. A ready-to-receive output drops whenever the receive buffer has no free slot. Two single-cycle interrupt outputs mark a completed transmission and each arriving character.

Top module: `uart_fc`

## Requirements
- R1: After reset, `txd` and `rts` are 1, `irq_rx` and `irq_tx` are 0, the control register reads 0 while `cts` is 0, and the data register reads 0 (valid bit 31 clear).
- R2: Each bit lasts (div+1) clock cycles, where div is control bits [15:0]. A transmitted frame is a 0 start bit, then data bits 0..7 in that order, then a 1 stop bit.
- R3: When parity is enabled (control bit 17), one bit follows the data bits. It is the XOR of the data bits for even parity (bit 18 = 0) and the inverse of that XOR for odd parity (bit 18 = 1). The same rule is used to check received characters.
- R4: A write to the data register (address 1, bits [7:0]) while the transmitter is busy (control bit 25 reads 1) is ignored.
- R5: With CTS gating on (control bit 20), a frame starts only while the synchronised `cts` is 1. A change on `cts` during a frame does not affect that frame.
- R6: Control bit 24 shows the `cts` input after a two-flop synchroniser.
- R7: The receiver starts a frame on a falling edge of `rxd` and samples each bit at mid-bit. A read of address 1 returns the oldest character in bits [7:0] with bit 31 set, and removes it from the buffer.
- R8: Data-read bit 28 flags a parity mismatch and bit 29 flags a stop bit received as 0. Both flags belong to that character and are recomputed for every character.
- R9: The receive buffer holds two characters in arrival order. A character that arrives while both slots are full is discarded. Control bit 26 reads 1 when the buffer is not empty, and bit 27 reads 1 when it is full.
- R10: With RTS enabled (control bit 19), `rts` is 0 while the buffer is full and 1 otherwise. With RTS disabled, `rts` is 1.
- R11: `irq_rx` pulses for exactly one cycle for every received character, including one that is discarded.
- R12: `irq_tx` pulses for exactly one cycle when the stop bit of a transmitted frame completes.
- R13: Clearing the enable bit (control bit 16) returns both directions to idle with `txd` at 1 and empties the receive buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the buffer at address 1) |
| reg_addr | input | 1 | 0 = control/status, 1 = data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts | input | 1 | Peer ready to accept (1 = clear to send) |
| rts | output | 1 | Ready to receive (1 = space available) |
| irq_rx | output | 1 | Character-arrived pulse |
| irq_tx | output | 1 | Frame-sent pulse |

## Verification
The bench keeps the default two-slot buffer and two-stage synchronisers and programs a divider of 9, so each bit lasts ten cycles. At that length every frame fits in about a hundred cycles, so overflow, parity modes, framing errors and mid-frame CTS changes all fit in one short run. With a ten-cycle bit, the synchroniser and edge-detect delays land the receive sample near the bit centre, and the bench checks the line at the middle of each bit. Because the buffer has only two slots, the third frame sent is enough to show the drop on overflow and the `rts` deassertion.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int DIV_W  = 16;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  localparam int CB_EN     = 16;
  localparam int CB_PEN    = 17;
  localparam int CB_PODD   = 18;
  localparam int CB_RTSEN  = 19;
  localparam int CB_CTSEN  = 20;
  localparam int SB_CTS    = 24;
  localparam int SB_BUSY   = 25;
  localparam int SB_AVAIL  = 26;
  localparam int SB_FULL   = 27;
  localparam int DB_PERR   = 28;
  localparam int DB_FERR   = 29;
  localparam int DB_VALID  = 31;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_t;

  typedef struct packed {
    logic              perr;
    logic              ferr;
    logic [DATA_W-1:0] data;
  } rx_word_t;

  function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic logic [DIV_W-1:0] mid_point(input logic [DIV_W-1:0] div);
    return div >> 1;
  endfunction

  function automatic logic last_bit(input logic [IDX_W-1:0] idx);
    return idx == IDX_W'(DATA_W - 1);
  endfunction
endpackage

// File: rtl/uart_sync.sv
module uart_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= RST_VAL;
        else        ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= {STAGES{RST_VAL}};
        else        ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic              pen,
  input  logic              podd,
  input  logic              may_start,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              txd,
  output logic              busy,
  output logic              active,
  output logic              done
);
  phase_t             phase;
  logic               pend;
  logic [DATA_W-1:0]  hold;
  logic [DATA_W-1:0]  shreg;
  logic [DIV_W-1:0]   cnt;
  logic [IDX_W-1:0]   idx;
  logic               par;
  logic               bit_end;
  logic               frame_end;

  assign active    = (phase != PH_IDLE);
  assign busy      = pend || active;
  assign bit_end   = active && (cnt == div);
  assign frame_end = bit_end && (phase == PH_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      pend  <= 1'b0;
      hold  <= '0;
      shreg <= '0;
      cnt   <= '0;
      idx   <= '0;
      par   <= 1'b0;
      txd   <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        phase <= PH_IDLE;
        pend  <= 1'b0;
        txd   <= 1'b1;
      end else begin
        if (load && !busy) begin
          pend <= 1'b1;
          hold <= load_data;
        end
        if (phase == PH_IDLE) begin
          if (pend && may_start) begin
            phase <= PH_START;
            pend  <= 1'b0;
            txd   <= 1'b0;
            cnt   <= '0;
            shreg <= hold;
            par   <= parity_of(hold, podd);
          end
        end else if (bit_end) begin
          cnt <= '0;
          case (phase)
            PH_START: begin
              phase <= PH_DATA;
              idx   <= '0;
              txd   <= shreg[0];
              shreg <= shreg >> 1;
            end
            PH_DATA: begin
              if (last_bit(idx)) begin
                phase <= pen ? PH_PAR : PH_STOP;
                txd   <= pen ? par : 1'b1;
              end else begin
                idx   <= idx + 1'b1;
                txd   <= shreg[0];
                shreg <= shreg >> 1;
              end
            end
            PH_PAR: begin
              phase <= PH_STOP;
              txd   <= 1'b1;
            end
            default: begin
              phase <= PH_IDLE;
              txd   <= 1'b1;
              done  <= 1'b1;
            end
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5: once a frame is on the line it runs to its stop bit whatever cts does
  assert_frame_no_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && active && !frame_end) |=> active);

  // R12: the sent pulse lasts one cycle and leaves the line idle
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_line_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> txd);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_fc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             pen,
  input  logic             podd,
  input  logic             rxd_s,
  output logic             valid,
  output rx_word_t         word
);
  phase_t             phase;
  logic               prev;
  logic [DIV_W-1:0]   cnt;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  shreg;
  logic               perr_r;
  logic               fall;

  assign fall = prev && !rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      prev   <= 1'b1;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      perr_r <= 1'b0;
      valid  <= 1'b0;
      word   <= '0;
    end else begin
      valid <= 1'b0;
      prev  <= rxd_s;
      if (!en) begin
        phase <= PH_IDLE;
      end else begin
        case (phase)
          PH_IDLE: begin
            if (fall) begin
              phase <= PH_START;
              cnt   <= '0;
            end
          end
          PH_START: begin
            if (cnt == mid_point(div)) begin
              cnt    <= '0;
              idx    <= '0;
              perr_r <= 1'b0;
              phase  <= rxd_s ? PH_IDLE : PH_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (cnt == div) begin
              cnt   <= '0;
              shreg <= {rxd_s, shreg[DATA_W-1:1]};
              if (last_bit(idx)) phase <= pen ? PH_PAR : PH_STOP;
              else               idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_PAR: begin
            if (cnt == div) begin
              cnt    <= '0;
              perr_r <= (rxd_s != parity_of(shreg, podd));
              phase  <= PH_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_STOP: begin
            if (cnt == div) begin
              cnt        <= '0;
              valid      <= 1'b1;
              word.perr  <= perr_r;
              word.ferr  <= !rxd_s;
              word.data  <= shreg;
              phase      <= PH_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // R11: each arriving character produces a single-cycle strobe
  assert_word_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R7: a frame only begins from idle on a falling line
  assert_start_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && en && !fall) |=> (phase == PH_IDLE));
endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf
  import uart_fc_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     push,
  input  rx_word_t din,
  input  logic     pop,
  output rx_word_t head,
  output logic     empty,
  output logic     full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_word_t         mem [DEPTH];
  logic [PTR_W-1:0] wp;
  logic [PTR_W-1:0] rp;
  logic [CNT_W-1:0] cnt;
  logic             do_push;
  logic             do_pop;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= next_ptr(wp);
      if (do_pop)  rp <= next_ptr(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: a character arriving at a full buffer leaves the stored ones untouched
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (full && $stable(head)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/uart_fc.sv
module uart_fc
  import uart_fc_pkg::*;
#(
  parameter int BUF_DEPTH   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rxd,
  output logic        txd,
  input  logic        cts,
  output logic        rts,
  output logic        irq_rx,
  output logic        irq_tx
);
  logic [DIV_W-1:0] cfg_div;
  logic             cfg_en;
  logic             cfg_pen;
  logic             cfg_podd;
  logic             cfg_rts_en;
  logic             cfg_cts_en;

  logic             rxd_s;
  logic             cts_s;
  logic             tx_busy;
  logic             tx_active;
  logic             tx_done;
  logic             rx_valid;
  rx_word_t         rx_word;
  rx_word_t         buf_head;
  logic             buf_empty;
  logic             buf_full;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata[31:CB_CTSEN+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_div    <= '0;
      cfg_en     <= 1'b0;
      cfg_pen    <= 1'b0;
      cfg_podd   <= 1'b0;
      cfg_rts_en <= 1'b0;
      cfg_cts_en <= 1'b0;
    end else if (reg_wr && !reg_addr) begin
      cfg_div    <= reg_wdata[DIV_W-1:0];
      cfg_en     <= reg_wdata[CB_EN];
      cfg_pen    <= reg_wdata[CB_PEN];
      cfg_podd   <= reg_wdata[CB_PODD];
      cfg_rts_en <= reg_wdata[CB_RTSEN];
      cfg_cts_en <= reg_wdata[CB_CTSEN];
    end
  end

  uart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  uart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cts_sync (
    .clk(clk), .rst_n(rst_n), .d(cts), .q(cts_s)
  );

  uart_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .div       (cfg_div),
    .pen       (cfg_pen),
    .podd      (cfg_podd),
    .may_start (!cfg_cts_en || cts_s),
    .load      (reg_wr && reg_addr),
    .load_data (reg_wdata[DATA_W-1:0]),
    .txd       (txd),
    .busy      (tx_busy),
    .active    (tx_active),
    .done      (tx_done)
  );

  uart_rx u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cfg_en),
    .div   (cfg_div),
    .pen   (cfg_pen),
    .podd  (cfg_podd),
    .rxd_s (rxd_s),
    .valid (rx_valid),
    .word  (rx_word)
  );

  uart_rxbuf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!cfg_en),
    .push  (rx_valid),
    .din   (rx_word),
    .pop   (reg_rd && reg_addr),
    .head  (buf_head),
    .empty (buf_empty),
    .full  (buf_full)
  );

  assign rts    = cfg_rts_en ? !buf_full : 1'b1;
  assign irq_rx = rx_valid;
  assign irq_tx = tx_done;

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr) begin
      reg_rdata[DIV_W-1:0] = cfg_div;
      reg_rdata[CB_EN]     = cfg_en;
      reg_rdata[CB_PEN]    = cfg_pen;
      reg_rdata[CB_PODD]   = cfg_podd;
      reg_rdata[CB_RTSEN]  = cfg_rts_en;
      reg_rdata[CB_CTSEN]  = cfg_cts_en;
      reg_rdata[SB_CTS]    = cts_s;
      reg_rdata[SB_BUSY]   = tx_busy;
      reg_rdata[SB_AVAIL]  = !buf_empty;
      reg_rdata[SB_FULL]   = buf_full;
    end else if (!buf_empty) begin
      reg_rdata[DATA_W-1:0] = buf_head.data;
      reg_rdata[DB_PERR]    = buf_head.perr;
      reg_rdata[DB_FERR]    = buf_head.ferr;
      reg_rdata[DB_VALID]   = 1'b1;
    end
  end

  // R5: a frame may only begin while clear-to-send allows it
  assert_cts_gates_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(!cfg_cts_en || cts_s));

  // R11: the arrival strobe reaches the pin even when the buffer is full
  assert_irq_when_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && buf_full) |-> irq_rx);

  // R10: rts follows buffer space once the flag is enabled
  assert_rts_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rts_en && rts) |-> !buf_full);
endmodule

// File: tb/uart_fc_bench.sv
module uart_fc_bench;
  localparam int DIVV = 9;
  localparam int BITP = DIVV + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rxd = 1'b1;
  logic        txd;
  logic        cts = 1'b0;
  logic        rts;
  logic        irq_rx;
  logic        irq_tx;

  int vectors = 0;
  int fails = 0;
  int rx_pulses = 0;
  int tx_pulses = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  uart_fc u_uart_fc (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd), .cts(cts),
    .rts(rts), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  always @(negedge clk) begin
    if (irq_rx === 1'b1) rx_pulses++;
    if (irq_tx === 1'b1) tx_pulses++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic ones_odd(input logic [7:0] d);
    int n = 0;
    for (int i = 0; i < 8; i++) if (d[i]) n++;
    return (n % 2) == 1;
  endfunction

  function automatic logic [31:0] ctrl(input bit en, pen, podd, rtse, ctse);
    return 32'(DIVV) | (32'(en) << 16) | (32'(pen) << 17) | (32'(podd) << 18)
         | (32'(rtse) << 19) | (32'(ctse) << 20);
  endfunction

  task automatic check_tx(input logic [7:0] d, input bit pen, input bit podd, input string req);
    logic exp_bits [11];
    int nb;
    int waited = 0;
    exp_bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) exp_bits[i + 1] = d[i];
    nb = 9;
    if (pen) begin
      exp_bits[nb] = podd ? !ones_odd(d) : ones_odd(d);
      nb++;
    end
    exp_bits[nb] = 1'b1;
    nb++;
    while (txd !== 1'b0 && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk({req, " start seen"}, 32'(waited < 3000), 32'd1);
    repeat (BITP / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      chk(req, {31'd0, txd}, {31'd0, exp_bits[i]});
      if (i < nb - 1) repeat (BITP) @(negedge clk);
    end
    repeat (BITP) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit pen, input bit podd,
                         input bit bad_par, input logic stop_bit);
    logic p;
    @(negedge clk);
    rxd = 1'b0;
    repeat (BITP) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BITP) @(negedge clk);
    end
    if (pen) begin
      p = podd ? !ones_odd(d) : ones_odd(d);
      rxd = bad_par ? !p : p;
      repeat (BITP) @(negedge clk);
    end
    rxd = stop_bit;
    repeat (BITP) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITP) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int low_seen;
    int rx_before;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", {31'd0, txd}, 32'd1);
    chk("R1 rts", {31'd0, rts}, 32'd1);
    chk("R1 irq", {30'd0, irq_rx, irq_tx}, 32'd0);
    rd(1'b0, r); chk("R1 ctrl", r, 32'd0);
    rd(1'b1, r); chk("R1 data", r, 32'd0);

    // R2 plain frame, R12 single done pulse
    wr(1'b0, ctrl(1, 0, 0, 0, 0));
    rd(1'b0, r); chk("R2 ctrl readback", r, ctrl(1, 0, 0, 0, 0));
    tx_pulses = 0;
    wr(1'b1, 32'hA5);
    check_tx(8'hA5, 0, 0, "R2 frame A5");
    chk("R12 one irq_tx", 32'(tx_pulses), 32'd1);

    // R3 even and odd parity
    wr(1'b0, ctrl(1, 1, 0, 0, 0));
    wr(1'b1, 32'h07);
    check_tx(8'h07, 1, 0, "R3 even parity");
    wr(1'b0, ctrl(1, 1, 1, 0, 0));
    wr(1'b1, 32'h07);
    check_tx(8'h07, 1, 1, "R3 odd parity");

    // R4 write during busy ignored
    wr(1'b0, ctrl(1, 0, 0, 0, 0));
    tx_pulses = 0;
    wr(1'b1, 32'h3C);
    wr(1'b1, 32'hFF);
    check_tx(8'h3C, 0, 0, "R4 first frame kept");
    low_seen = 0;
    repeat (3 * BITP) begin
      @(negedge clk);
      if (txd !== 1'b1) low_seen++;
    end
    chk("R4 no second frame", 32'(low_seen), 32'd0);
    chk("R4 one irq_tx", 32'(tx_pulses), 32'd1);
    rd(1'b0, r); chk("R4 idle busy bit", {31'd0, r[25]}, 32'd0);

    // R5 cts gating, held off then mid-frame change ignored
    wr(1'b0, ctrl(1, 0, 0, 0, 1));
    cts = 1'b0;
    wr(1'b1, 32'h81);
    low_seen = 0;
    repeat (60) begin
      @(negedge clk);
      if (txd !== 1'b1) low_seen++;
    end
    chk("R5 held by cts", 32'(low_seen), 32'd0);
    rd(1'b0, r); chk("R5 busy while held", {31'd0, r[25]}, 32'd1);
    fork
      check_tx(8'h81, 0, 0, "R5 frame after cts");
      begin
        cts = 1'b1;
        repeat (40) @(negedge clk);
        cts = 1'b0;
      end
    join

    // R6 cts status bit
    cts = 1'b1;
    repeat (3) @(negedge clk);
    rd(1'b0, r); chk("R6 cts high", {31'd0, r[24]}, 32'd1);
    cts = 1'b0;
    repeat (3) @(negedge clk);
    rd(1'b0, r); chk("R6 cts low", {31'd0, r[24]}, 32'd0);

    // R7 reception
    wr(1'b0, ctrl(1, 0, 0, 1, 0));
    send_rx(8'h5A, 0, 0, 0, 1'b1);
    rd(1'b0, r); chk("R9 avail bit", {31'd0, r[26]}, 32'd1);
    rd(1'b1, r); chk("R7 rx 5A", r, 32'h8000_005A);
    rd(1'b1, r); chk("R7 popped", r, 32'd0);

    // R8 error flags
    wr(1'b0, ctrl(1, 1, 0, 1, 0));
    send_rx(8'h33, 1, 0, 1, 1'b1);
    rd(1'b1, r); chk("R8 parity error", r, 32'h9000_0033);
    send_rx(8'h6E, 1, 0, 0, 1'b0);
    rd(1'b1, r); chk("R8 frame error", r, 32'hA000_006E);
    send_rx(8'h6E, 1, 1, 0, 1'b1);
    wr(1'b0, ctrl(1, 1, 1, 1, 0));
    send_rx(8'hC4, 1, 1, 0, 1'b1);
    rd(1'b1, r);
    chk("R8 even-setup odd frame mismatch", r, 32'h9000_006E);
    rd(1'b1, r); chk("R8 flags cleared", r, 32'h8000_00C4);

    // R9 R10 R11 double buffer, overflow, rts, irq
    wr(1'b0, ctrl(1, 0, 0, 1, 0));
    rx_before = rx_pulses;
    send_rx(8'hA1, 0, 0, 0, 1'b1);
    chk("R10 rts one stored", {31'd0, rts}, 32'd1);
    send_rx(8'hB2, 0, 0, 0, 1'b1);
    chk("R10 rts full", {31'd0, rts}, 32'd0);
    rd(1'b0, r); chk("R9 full bit", {31'd0, r[27]}, 32'd1);
    send_rx(8'hC3, 0, 0, 0, 1'b1);
    chk("R11 irq per word", 32'(rx_pulses - rx_before), 32'd3);
    chk("R10 rts still low", {31'd0, rts}, 32'd0);
    rd(1'b1, r); chk("R9 first A1", r, 32'h8000_00A1);
    chk("R10 rts after pop", {31'd0, rts}, 32'd1);
    rd(1'b1, r); chk("R9 second B2", r, 32'h8000_00B2);
    rd(1'b1, r); chk("R9 third dropped", r, 32'd0);
    send_rx(8'h11, 0, 0, 0, 1'b1);
    send_rx(8'h22, 0, 0, 0, 1'b1);
    wr(1'b0, ctrl(1, 0, 0, 0, 0));
    chk("R10 rts disabled", {31'd0, rts}, 32'd1);

    // R13 disable clears
    wr(1'b0, ctrl(0, 0, 0, 0, 0));
    @(negedge clk);
    rd(1'b1, r); chk("R13 buffer emptied", r, 32'd0);
    chk("R13 txd idle", {31'd0, txd}, 32'd1);
    rd(1'b0, r); chk("R13 ctrl", r, 32'(DIVV));

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule